// File: doc/BRIEF.md
# Tuning Window Tap Selector

After a tuning sweep, this block picks the sampling tap. The sweep probes each of `n` delay taps twice, which gives `2n` probes. Probe `i` exercises tap `i mod n`. Two bitmaps describe the sweep:

- a **pass map**, where a bit is set when the tuning command for that probe completed;
- a **compare map**, where a bit is set when the sample comparator reported no mismatch for that probe.

The block folds the two passes together. A tap that failed in either pass is treated as failed in both. The block then looks for the longest unbroken run of passing probes and selects the tap at the centre of that run. When every probe passed, the pass map carries no position information. In that case the block repeats the run search on the folded compare map and takes the centre of that run instead.

The host loads the maps and the tap count, then pulses `start`. The block works one probe per clock and raises `done` for a single cycle. On success it asserts `sel_ok`, drives the chosen tap and enables automatic retuning. When no acceptable window exists it asserts `sel_fail`. A tap count of zero, or one too large for the map width, skips the search entirely.

Top module: `tap_window_selector`

## Requirements
- R1: For each tap `t < n`, the folded pass bit is `pass_map[t] & pass_map[t+n]`. The folded compare bit is formed the same way from `cmp_map`, independently of the pass map. A failure in either pass therefore removes the tap from both halves of the scanned sequence.
- R2: The scan walks probes `0..2n-1`, where probe `i` takes the folded bit of tap `i mod n`. It keeps the longest run of ones. When two runs tie, the earliest one is kept. A run still open at probe `2n-1` is also considered.
- R3: If the longest pass run is shorter than `2n`, the selection succeeds only when that run is at least `MIN_RUN` probes long (3 by default). Otherwise it fails.
- R4: If the longest pass run covers all `2n` probes, the longest run of the folded compare map is used instead. The selection succeeds only if that run is nonzero.
- R5: The selected tap equals `((start + end) / 2) mod n`, where `start` and `end` are the first and last probe indices of the accepted run and the division is integer division.
- R6: On success, `sel_ok` and `retune_en` are 1 and `tap_sel` takes the new tap. On failure, `sel_fail` is 1, `retune_en` is 0 and `tap_sel` keeps its previous value. `sel_ok` and `sel_fail` are never 1 together. Reset clears all outputs to 0.
- R7: When `tap_count` is 0 or `2*tap_count >= MAP_W`, no scan is performed. `done` and `sel_fail` appear in the cycle right after the edge that accepts `start`.
- R8: For an accepted `start`, `done` rises `3n+2` cycles later when the pass map decides the outcome, and `5n+4` cycles later when the compare map is consulted. `busy` is 1 from the accepting edge until `done`. `done` lasts exactly one cycle.
- R9: `start` is accepted only while idle. A `start` pulse during a selection has no effect on that selection's timing or result. Accepting `start` clears `sel_ok`, `sel_fail` and `retune_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection (accepted when idle) |
| pass_map | input | MAP_W | Per-probe command success bits |
| cmp_map | input | MAP_W | Per-probe comparator-clean bits |
| tap_count | input | $clog2(MAP_W)+1 | Number of taps `n` |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_ok | output | 1 | Last selection found a window |
| sel_fail | output | 1 | Last selection found no window, or was skipped |
| retune_en | output | 1 | Automatic retune enable |
| tap_sel | output | $clog2(MAP_W/2) | Selected sampling tap |

## Verification
The directed cases each separate one branch of the selection rules:

- **Full pass with a clean compare map.** The accepted run is still open at the end of the scan, and the centre lands on tap `n-1`.
- **Full pass with an all-zero compare map.** This isolates the compare-path failure.
- **Windows of exactly two and three taps.** These pin the minimum-length threshold.
- **A failure only in the second pass.** This shows the fold rather than a plain run search.
- **Equal-length runs.** These expose the earliest-run tie rule.
- **Runs that wrap around tap `n-1`.** These check the centre modulo `n`.
- **Out-of-range tap counts, a start pulse during a scan, and a failure following a success.** These cover the skip path, ignored starts and tap hold.

Random maps with varying `n` then mix all branches against the bench model.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FOLD,
        ST_SCAN_P,
        ST_END_P,
        ST_DEC_P,
        ST_SCAN_C,
        ST_END_C,
        ST_DEC_C,
        ST_DONE
    } tws_state_t;

    typedef struct packed {
        logic ok;
        logic fail;
        logic retune;
    } tws_flags_t;

    // Centre of a run in probe space, folded back into tap space.
    // Run bounds are below 2n, so one subtraction replaces the modulo.
    function automatic int unsigned centre_tap(input int unsigned s,
                                               input int unsigned e,
                                               input int unsigned n);
        int unsigned m;
        m = (s + e) / 2;
        return (m >= n) ? (m - n) : m;
    endfunction

endpackage

// File: rtl/tws_fold.sv
module tws_fold #(
    parameter int MAP_W = 32
) (
    input  logic [1:0][MAP_W-1:0]       maps,
    input  logic [$clog2(MAP_W):0]      tap_cnt,
    input  logic [$clog2(MAP_W/2)-1:0]  tap_idx,
    output logic [1:0]                  ok
);
    localparam int IDX_W = $clog2(MAP_W) + 1;

    logic [IDX_W-1:0] lo_pos;
    logic [IDX_W-1:0] hi_pos;

    assign lo_pos = IDX_W'(tap_idx);
    assign hi_pos = lo_pos + tap_cnt;

    // Same folding rule applied to each map independently.
    for (genvar g = 0; g < 2; g++) begin : g_map
        logic [MAP_W-1:0] lo_sh;
        logic [MAP_W-1:0] hi_sh;
        assign lo_sh = maps[g] >> lo_pos;
        assign hi_sh = maps[g] >> hi_pos;
        assign ok[g] = lo_sh[0] & hi_sh[0];
    end

endmodule

// File: rtl/tws_run_tracker.sv
module tws_run_tracker #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic             fin,
    input  logic             bit_in,
    input  logic [IDX_W-1:0] pos,
    output logic [IDX_W-1:0] best_len,
    output logic [IDX_W-1:0] run_start,
    output logic [IDX_W-1:0] run_end
);
    logic [IDX_W-1:0] cur_len;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_len   <= '0;
            best_len  <= '0;
            run_start <= '0;
            run_end   <= '0;
        end else if (step && bit_in) begin
            cur_len <= cur_len + 1'b1;
        end else if (step || fin) begin
            // Strictly longer only: an equal later run never displaces.
            if (cur_len > best_len) begin
                best_len  <= cur_len;
                run_start <= pos - cur_len;
                run_end   <= pos - 1'b1;
            end
            cur_len <= '0;
        end
    end

    p_run_order_r2: assert property (@(posedge clk) disable iff (rst)
        (best_len != '0) |-> (run_start <= run_end));

    p_run_len_r2: assert property (@(posedge clk) disable iff (rst)
        (best_len != '0) |-> ((run_end - run_start + 1'b1) == best_len));

endmodule

// File: rtl/tap_window_selector.sv
module tap_window_selector
    import tws_pkg::*;
#(
    parameter int MAP_W   = 32,
    parameter int MIN_RUN = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [MAP_W-1:0]           pass_map,
    input  logic [MAP_W-1:0]           cmp_map,
    input  logic [$clog2(MAP_W):0]     tap_count,
    output logic                       busy,
    output logic                       done,
    output logic                       sel_ok,
    output logic                       sel_fail,
    output logic                       retune_en,
    output logic [$clog2(MAP_W/2)-1:0] tap_sel
);
    localparam int IDX_W  = $clog2(MAP_W) + 1;
    localparam int HALF   = MAP_W / 2;
    localparam int HALF_W = $clog2(HALF);

    tws_state_t       state;
    tws_flags_t       flags_q;
    logic [MAP_W-1:0] pass_q, cmp_q;
    logic [IDX_W-1:0] n_q;
    logic [IDX_W-1:0] idx;
    logic [HALF_W-1:0] tpos;
    logic [HALF-1:0]  pass_fold_q, cmp_fold_q;
    logic [HALF_W-1:0] tap_q;

    logic [1:0]       fold_ok;
    logic [IDX_W:0]   two_n;
    logic             last_tap, last_probe, skip, full_pass;
    logic [HALF-1:0]  scan_vec, scan_sh;
    logic             scan_bit;
    logic             trk_clr, trk_step, trk_fin;
    logic [IDX_W-1:0] trk_pos, best_len, run_start, run_end;
    logic [HALF_W-1:0] centre;

    assign two_n      = {n_q, 1'b0};
    assign last_tap   = (IDX_W'(tpos) == (n_q - 1'b1));
    assign last_probe = ({1'b0, idx} == (two_n - 1'b1));
    assign skip       = (tap_count == '0) ||
                        ({tap_count, 1'b0} >= (IDX_W+1)'(MAP_W));
    assign full_pass  = ({1'b0, best_len} == two_n);

    tws_fold #(.MAP_W(MAP_W)) u_fold (
        .maps    ({cmp_q, pass_q}),
        .tap_cnt (n_q),
        .tap_idx (tpos),
        .ok      (fold_ok)
    );

    assign scan_vec = (state == ST_SCAN_C) ? cmp_fold_q : pass_fold_q;
    assign scan_sh  = scan_vec >> tpos;
    assign scan_bit = scan_sh[0];

    assign trk_clr  = ((state == ST_FOLD) && last_tap) ||
                      ((state == ST_DEC_P) && full_pass);
    assign trk_step = (state == ST_SCAN_P) || (state == ST_SCAN_C);
    assign trk_fin  = (state == ST_END_P) || (state == ST_END_C);
    assign trk_pos  = trk_fin ? two_n[IDX_W-1:0] : idx;

    tws_run_tracker #(.IDX_W(IDX_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .clr       (trk_clr),
        .step      (trk_step),
        .fin       (trk_fin),
        .bit_in    (scan_bit),
        .pos       (trk_pos),
        .best_len  (best_len),
        .run_start (run_start),
        .run_end   (run_end)
    );

    assign centre = HALF_W'(centre_tap(32'(run_start), 32'(run_end), 32'(n_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            flags_q     <= '0;
            pass_q      <= '0;
            cmp_q       <= '0;
            n_q         <= '0;
            idx         <= '0;
            tpos        <= '0;
            pass_fold_q <= '0;
            cmp_fold_q  <= '0;
            tap_q       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pass_q <= pass_map;
                        cmp_q  <= cmp_map;
                        n_q    <= tap_count;
                        tpos   <= '0;
                        idx    <= '0;
                        if (skip) begin
                            flags_q <= '{ok: 1'b0, fail: 1'b1, retune: 1'b0};
                            state   <= ST_DONE;
                        end else begin
                            flags_q <= '0;
                            state   <= ST_FOLD;
                        end
                    end
                end
                ST_FOLD: begin
                    pass_fold_q[tpos] <= fold_ok[0];
                    cmp_fold_q[tpos]  <= fold_ok[1];
                    if (last_tap) begin
                        tpos  <= '0;
                        idx   <= '0;
                        state <= ST_SCAN_P;
                    end else begin
                        tpos <= tpos + 1'b1;
                    end
                end
                ST_SCAN_P, ST_SCAN_C: begin
                    idx  <= idx + 1'b1;
                    tpos <= last_tap ? '0 : tpos + 1'b1;
                    if (last_probe)
                        state <= (state == ST_SCAN_P) ? ST_END_P : ST_END_C;
                end
                ST_END_P: state <= ST_DEC_P;
                ST_END_C: state <= ST_DEC_C;
                ST_DEC_P: begin
                    if (full_pass) begin
                        idx   <= '0;
                        tpos  <= '0;
                        state <= ST_SCAN_C;
                    end else begin
                        flags_q.ok     <= (best_len >= IDX_W'(MIN_RUN));
                        flags_q.fail   <= (best_len <  IDX_W'(MIN_RUN));
                        flags_q.retune <= (best_len >= IDX_W'(MIN_RUN));
                        if (best_len >= IDX_W'(MIN_RUN)) tap_q <= centre;
                        state <= ST_DONE;
                    end
                end
                ST_DEC_C: begin
                    flags_q.ok     <= (best_len != '0);
                    flags_q.fail   <= (best_len == '0);
                    flags_q.retune <= (best_len != '0);
                    if (best_len != '0) tap_q <= centre;
                    state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE) && (state != ST_DONE);
    assign done      = (state == ST_DONE);
    assign sel_ok    = flags_q.ok;
    assign sel_fail  = flags_q.fail;
    assign retune_en = flags_q.retune;
    assign tap_sel   = tap_q;

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(sel_ok && sel_fail));

    p_tap_range_r5: assert property (@(posedge clk) disable iff (rst)
        sel_ok |-> (IDX_W'(tap_sel) < n_q));

    p_fail_holds_tap_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (!done || sel_ok || $stable(tap_sel)));

    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    p_skip_fast_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && skip) |=> (done && sel_fail));

endmodule

// File: tb/tap_window_selector_bench.sv
module tap_window_selector_bench;
    localparam int MW = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [MW-1:0] pass_map = '0;
    logic [MW-1:0] cmp_map = '0;
    logic [5:0]  tap_count = '0;
    logic        busy, done, sel_ok, sel_fail, retune_en;
    logic [3:0]  tap_sel;

    int total = 0;
    int bad = 0;
    int last_tap = 0;

    always #5 clk = ~clk;

    tap_window_selector #(.MAP_W(MW), .MIN_RUN(3)) u_tap_window_selector (
        .clk(clk), .rst(rst), .start(start), .pass_map(pass_map),
        .cmp_map(cmp_map), .tap_count(tap_count), .busy(busy), .done(done),
        .sel_ok(sel_ok), .sel_fail(sel_fail), .retune_en(retune_en),
        .tap_sel(tap_sel)
    );

    task automatic chk(input bit good, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic void longest(input logic [63:0] m, input int len,
                                    output int best, output int s, output int e);
        int cur = 0;
        best = 0; s = 0; e = 0;
        for (int i = 0; i <= len; i++) begin
            if (i < len && m[i]) cur++;
            else begin
                if (cur > best) begin best = cur; s = i - cur; e = i - 1; end
                cur = 0;
            end
        end
    endfunction

    // Behavioural reference: returns outcome, tap and done latency.
    function automatic void model(input logic [MW-1:0] p, input logic [MW-1:0] c,
                                  input int n, output bit ok, output int tap,
                                  output int lat, output bit cpath);
        logic [63:0] pf, cf;
        int best, s, e;
        ok = 0; tap = 0; lat = 0; cpath = 0; pf = '0; cf = '0;
        if (n == 0 || 2 * n >= MW) return;
        for (int i = 0; i < 2 * n; i++) begin
            pf[i] = p[i % n] & p[(i % n) + n];
            cf[i] = c[i % n] & c[(i % n) + n];
        end
        longest(pf, 2 * n, best, s, e);
        if (best == 2 * n) begin
            cpath = 1;
            lat = 5 * n + 4;
            longest(cf, 2 * n, best, s, e);
            ok = (best > 0);
        end else begin
            lat = 3 * n + 2;
            ok = (best >= 3);
        end
        tap = ((s + e) / 2) % n;
    endfunction

    task automatic run_case(input logic [MW-1:0] p, input logic [MW-1:0] c,
                            input int n, input bit poke);
        bit ok, cpath;
        int tap, lat, exp_tap;
        string rtag;
        model(p, c, n, ok, tap, lat, cpath);
        rtag = (lat == 0) ? "R7" : (cpath ? "R4" : "R3");
        exp_tap = ok ? tap : last_tap;
        @(negedge clk);
        pass_map = p; cmp_map = c; tap_count = 6'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= lat; k++) begin
            chk(done == (k == lat), "R8", "done", int'(done), int'(k == lat));
            chk(busy == (k < lat), "R8", "busy", int'(busy), int'(k < lat));
            if (k == 0 && lat > 0)
                chk(!sel_ok && !sel_fail && !retune_en, "R9", "status cleared",
                    int'({sel_ok, sel_fail, retune_en}), 0);
            if (k == lat) begin
                chk(sel_ok == ok, rtag, "sel_ok", int'(sel_ok), int'(ok));
                chk(sel_fail == !ok, rtag, "sel_fail", int'(sel_fail), int'(!ok));
                chk(retune_en == ok, "R6", "retune_en", int'(retune_en), int'(ok));
                chk(int'(tap_sel) == exp_tap, ok ? "R5" : "R6", "tap_sel",
                    int'(tap_sel), exp_tap);
            end
            if (poke && k == 1) begin
                // R9: a start with different inputs while busy must not matter
                start = 1'b1; pass_map = ~p; cmp_map = ~c; tap_count = 6'd4;
            end
            if (poke && k == 2) start = 1'b0;
            @(negedge clk);
        end
        last_tap = exp_tap;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R8 watchdog expired act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: reset state
        chk({busy, done, sel_ok, sel_fail, retune_en} == 5'b0, "R6", "reset flags",
            int'({busy, done, sel_ok, sel_fail, retune_en}), 0);
        chk(tap_sel == 4'd0, "R6", "reset tap", int'(tap_sel), 0);

        run_case(32'h0000FFFF, 32'h0000FFFF, 8, 0); // R4 full pass, open run -> tap 7
        run_case(32'h0000FFFF, 32'h0000FFF7, 8, 0); // R1 R4 compare fold
        run_case(32'h0000FFFF, 32'h00000000, 8, 0); // R4 no compare run -> fail
        run_case(32'h00000C0C, 32'h0, 8, 0);        // R3 run of 2 -> fail, tap held
        run_case(32'h00001C1C, 32'h0, 8, 0);        // R3 run of 3 -> tap 3
        run_case(32'h0000141C, 32'h0, 8, 0);        // R1 second-pass failure kills tap
        run_case(32'h00007777, 32'h0, 8, 0);        // R2 tie keeps earliest -> tap 1
        run_case(32'h0000C3C3, 32'h0, 8, 0);        // R5 wrap: run 6..9 -> tap 7
        run_case(32'h0000E0E0, 32'h0, 8, 0);        // R2 later equal run ignored -> tap 6
        run_case(32'h000000FF, 32'h000000EE, 4, 0); // R4 n=4 compare path -> tap 2
        run_case(32'h3FFFFFFF, 32'h3FFFFFFF, 15, 0);// R5 largest n -> tap 14
        run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 16, 0);// R7 2n == width -> skip
        run_case(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0); // R7 zero taps -> skip
        run_case(32'h00001C1C, 32'h0, 8, 1);        // R9 start during scan ignored
        run_case(32'h00000808, 32'h0, 8, 0);        // R6 fail after success holds tap

        for (int r = 0; r < 60; r++) begin
            int n;
            logic [MW-1:0] p, c;
            n = 2 + int'($urandom % 14);
            p = ((r % 3) == 0) ? 32'hFFFFFFFF : ($urandom | $urandom);
            c = $urandom | $urandom;
            run_case(p, c, n, (r % 7) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule